// File: doc/BRIEF.md
# Bus Loopback Self-Test Controller

This block runs a one-word loopback self-test for a terminal that has two redundant serial buses. The host loads a 16-bit test pattern. It then writes a control word that picks the bus and the sync type and requests a start. The block offers the pattern to an external encoder through a valid/ready handshake. It waits for the decoder to return one word. It stores that word in a read-only capture register and sets either a pass flag or a fail flag.

A test fails if any of four things happens:
- the decoder flags a Manchester error;
- the decoder flags a parity error;
- the returned sync type differs from the one sent;
- the returned data differs from the pattern.

A test also fails if no word comes back within a fixed number of clock cycles. A start request is honoured only while the external test-enable pin is high.

There are two resets. The hardware master reset clears everything. The software reset clears control, status, the capture register and any test in progress, but it leaves the pattern register untouched.

Top module: `busloop_selftest`

## Requirements
- R1: After master reset (`rst_n` low), `pat_q`, `rx_q`, `ctl_cmd_sync`, `ctl_bus_b`, `busy`, `pass`, `fail` and `enc_valid` are all 0.
- R2: A write with `wr_sel`=0 loads `wr_data` into `pat_q` on the next edge when no test is running. While `busy` is 1, writes to the pattern and to the control word are both ignored.
- R3: The control word bit positions are: bit 0 = sync select (1 = command sync, 0 = data sync), bit 1 = bus select (0 = bus A, 1 = bus B) and bit 2 = start. The select bits take the written value whenever the block is idle. Start is accepted only if `test_en` is high in the write cycle. A start written while `test_en` is low leaves `busy`, `pass` and `fail` unchanged.
- R4: On the edge that accepts a start, `busy` goes to 1 and `pass` and `fail` both go to 0. Both flags stay 0 for as long as `busy` is 1.
- R5: During a test, `enc_valid` is high from the edge after the start until the edge at which `enc_ready` is seen high. While it is high, `enc_data` equals `pat_q`, `enc_cmd_sync` equals the sync select bit and `enc_bus_b` equals the bus select bit.
- R6: The first `dec_strobe` after the encoder handshake has these effects on that same edge: `dec_data` is loaded into `rx_q` and `busy` clears.
- R7: If that returned word has no Manchester error, no parity error, a sync type equal to the one sent and data equal to `pat_q`, then `pass`=1 and `fail`=0.
- R8: Any one of these sets `fail`=1 and `pass`=0: `dec_manch_err`, `dec_par_err`, `dec_cmd_sync` different from the sent sync, or `dec_data` different from `pat_q`.
- R9: If no strobe arrives, the test ends exactly TIMEOUT_CYC cycles after the handshake edge. At that point `fail`=1 and `busy`=0, and `rx_q` is unchanged.
- R10: `soft_rst` has these effects: it clears `ctl_cmd_sync`, `ctl_bus_b`, `busy`, `pass`, `fail` and `rx_q`; it aborts any test and drops `enc_valid`; it leaves `pat_q` unchanged.
- R11: `pass` and `fail` are never 1 at the same time.
- R12: A `dec_strobe` that arrives while no test is waiting for a reply leaves `rx_q` and the status flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low, asynchronous |
| soft_rst | input | 1 | Synchronous software reset, active high |
| test_en | input | 1 | External test-enable pin |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | Write target: 0 = pattern, 1 = control word |
| wr_data | input | 16 | Host write data |
| pat_q | output | 16 | Pattern register readback |
| rx_q | output | 16 | Captured receive word (read-only) |
| ctl_cmd_sync | output | 1 | Sync select: 1 = command sync |
| ctl_bus_b | output | 1 | Bus select: 1 = bus B |
| busy | output | 1 | Start bit; high while a test runs |
| pass | output | 1 | Last test passed |
| fail | output | 1 | Last test failed |
| enc_valid | output | 1 | Word offered to the encoder |
| enc_ready | input | 1 | Encoder accepts the word |
| enc_data | output | 16 | Word to transmit |
| enc_cmd_sync | output | 1 | Sync type to transmit |
| enc_bus_b | output | 1 | Bus to transmit on |
| dec_strobe | input | 1 | Decoder word strobe |
| dec_data | input | 16 | Decoded data |
| dec_cmd_sync | input | 1 | Decoded sync type: 1 = command |
| dec_manch_err | input | 1 | Decoder Manchester error |
| dec_par_err | input | 1 | Decoder parity error |

## Verification
Faults in the sequencer show up at the ports within a cycle or two. A stuck send state keeps `enc_valid` high after the handshake. A missed return to idle leaves `busy` high, and then `pass` and `fail` never settle. A timer that is off by one cycle moves the fall of `busy` in a timeout test, and the bench counts that fall to the exact cycle. A fault in the error collection gives a wrong verdict on the edge of the strobe. Each of the four failure causes is therefore driven on its own, alongside a clean echo on each bus and with each sync type.

// File: rtl/busloop_pkg.sv
`timescale 1ns/1ps
package busloop_pkg;
   // control word bit positions
   localparam int unsigned CTL_SYNC  = 0;
   localparam int unsigned CTL_BUS   = 1;
   localparam int unsigned CTL_START = 2;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_WAIT = 2'd2
   } seq_st_t;

   // decoder side-band qualifiers
   typedef struct packed {
      logic cmd_sync;
      logic manch_err;
      logic par_err;
   } dec_flags_t;
endpackage

// File: rtl/busloop_judge.sv
`timescale 1ns/1ps
module busloop_judge
   import busloop_pkg::*;
#(
   parameter int unsigned WORD_W     = 16,
   parameter bit          CHECK_DATA = 1'b1
) (
   input  logic [WORD_W-1:0] ref_word,
   input  logic              ref_cmd_sync,
   input  logic [WORD_W-1:0] got_word,
   input  dec_flags_t        got_flags,
   output logic              err
);
   logic line_err;
   logic sync_err;
   logic data_err;

   assign line_err = got_flags.manch_err | got_flags.par_err;
   assign sync_err = got_flags.cmd_sync ^ ref_cmd_sync;

   generate
      if (CHECK_DATA) begin : g_cmp
         assign data_err = |(got_word ^ ref_word);
      end else begin : g_nocmp
         assign data_err = 1'b0;
      end
   endgenerate

   assign err = line_err | sync_err | data_err;
endmodule

// File: rtl/busloop_seq.sv
`timescale 1ns/1ps
module busloop_seq
   import busloop_pkg::*;
#(
   parameter int unsigned TIMEOUT_CYC = 1600
) (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic launch,
   input  logic enc_ready,
   input  logic dec_strobe,
   output logic enc_valid,
   output logic fin_word,
   output logic fin_timeout
);
   seq_st_t st_q, st_d;
   logic    tmo_hit;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (launch)    st_d = ST_SEND;
         ST_SEND: if (enc_ready) st_d = ST_WAIT;
         ST_WAIT: if (dec_strobe || tmo_hit) st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
      if (soft_rst) st_d = ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   generate
      if (TIMEOUT_CYC > 0) begin : g_timer
         localparam int unsigned CNT_W = (TIMEOUT_CYC < 2) ? 1 : $clog2(TIMEOUT_CYC);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          cnt_q <= '0;
            else if (st_q != ST_WAIT || soft_rst) cnt_q <= '0;
            else if (cnt_q != LAST)              cnt_q <= cnt_q + 1'b1;
         end
         assign tmo_hit = (st_q == ST_WAIT) && (cnt_q == LAST);
      end else begin : g_notimer
         assign tmo_hit = 1'b0;
      end
   endgenerate

   assign enc_valid   = (st_q == ST_SEND);
   assign fin_word    = (st_q == ST_WAIT) && dec_strobe && !soft_rst;
   assign fin_timeout = (st_q == ST_WAIT) && !dec_strobe && tmo_hit && !soft_rst;
endmodule

// File: rtl/busloop_regs.sv
`timescale 1ns/1ps
module busloop_regs
   import busloop_pkg::*;
#(
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              test_en,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              fin_word,
   input  logic              fin_timeout,
   input  logic              fin_err,
   input  logic [WORD_W-1:0] cap_data,
   output logic              launch,
   output logic [WORD_W-1:0] pat_q,
   output logic [WORD_W-1:0] rx_q,
   output logic              cmd_sync_q,
   output logic              bus_b_q,
   output logic              busy_q,
   output logic              pass_q,
   output logic              fail_q
);
   logic idle_wr_pat;
   logic idle_wr_ctl;

   assign idle_wr_pat = wr_en && !wr_sel && !busy_q;
   assign idle_wr_ctl = wr_en &&  wr_sel && !busy_q && !soft_rst;
   assign launch      = idle_wr_ctl && wr_data[CTL_START] && test_en;

   // pattern: master reset only
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           pat_q <= '0;
      else if (idle_wr_pat) pat_q <= wr_data;
   end

   // control and status: master and software reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_sync_q <= 1'b0;
         bus_b_q    <= 1'b0;
         busy_q     <= 1'b0;
         pass_q     <= 1'b0;
         fail_q     <= 1'b0;
         rx_q       <= '0;
      end else if (soft_rst) begin
         cmd_sync_q <= 1'b0;
         bus_b_q    <= 1'b0;
         busy_q     <= 1'b0;
         pass_q     <= 1'b0;
         fail_q     <= 1'b0;
         rx_q       <= '0;
      end else begin
         if (idle_wr_ctl) begin
            cmd_sync_q <= wr_data[CTL_SYNC];
            bus_b_q    <= wr_data[CTL_BUS];
         end
         if (launch) begin
            busy_q <= 1'b1;
            pass_q <= 1'b0;
            fail_q <= 1'b0;
         end else if (fin_word) begin
            busy_q <= 1'b0;
            rx_q   <= cap_data;
            pass_q <= !fin_err;
            fail_q <= fin_err;
         end else if (fin_timeout) begin
            busy_q <= 1'b0;
            pass_q <= 1'b0;
            fail_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/busloop_selftest.sv
`timescale 1ns/1ps
module busloop_selftest
   import busloop_pkg::*;
#(
   parameter int unsigned WORD_W      = 16,
   parameter int unsigned TIMEOUT_CYC = 1600
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              test_en,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [WORD_W-1:0] wr_data,
   output logic [WORD_W-1:0] pat_q,
   output logic [WORD_W-1:0] rx_q,
   output logic              ctl_cmd_sync,
   output logic              ctl_bus_b,
   output logic              busy,
   output logic              pass,
   output logic              fail,
   output logic              enc_valid,
   input  logic              enc_ready,
   output logic [WORD_W-1:0] enc_data,
   output logic              enc_cmd_sync,
   output logic              enc_bus_b,
   input  logic              dec_strobe,
   input  logic [WORD_W-1:0] dec_data,
   input  logic              dec_cmd_sync,
   input  logic              dec_manch_err,
   input  logic              dec_par_err
);
   generate
      if (WORD_W <= CTL_START) begin : g_bad_width
         $error("WORD_W must hold the control word bits");
      end
   endgenerate

   logic       launch;
   logic       fin_word;
   logic       fin_timeout;
   logic       fin_err;
   dec_flags_t flags;

   assign flags = '{cmd_sync: dec_cmd_sync, manch_err: dec_manch_err, par_err: dec_par_err};

   busloop_regs #(.WORD_W(WORD_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .test_en(test_en),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .fin_word(fin_word), .fin_timeout(fin_timeout), .fin_err(fin_err),
      .cap_data(dec_data), .launch(launch),
      .pat_q(pat_q), .rx_q(rx_q), .cmd_sync_q(ctl_cmd_sync), .bus_b_q(ctl_bus_b),
      .busy_q(busy), .pass_q(pass), .fail_q(fail)
   );

   busloop_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .launch(launch),
      .enc_ready(enc_ready), .dec_strobe(dec_strobe),
      .enc_valid(enc_valid), .fin_word(fin_word), .fin_timeout(fin_timeout)
   );

   busloop_judge #(.WORD_W(WORD_W), .CHECK_DATA(1'b1)) u_judge (
      .ref_word(pat_q), .ref_cmd_sync(ctl_cmd_sync),
      .got_word(dec_data), .got_flags(flags), .err(fin_err)
   );

   assign enc_data     = pat_q;
   assign enc_cmd_sync = ctl_cmd_sync;
   assign enc_bus_b    = ctl_bus_b;
endmodule

// File: rtl/busloop_chk.sv
`timescale 1ns/1ps
module busloop_chk #(
   parameter int unsigned WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              soft_rst,
   input logic              test_en,
   input logic              wr_en,
   input logic              wr_sel,
   input logic              busy,
   input logic              pass,
   input logic              fail,
   input logic              enc_valid,
   input logic              enc_ready,
   input logic [WORD_W-1:0] enc_data,
   input logic              enc_cmd_sync,
   input logic              enc_bus_b,
   input logic [WORD_W-1:0] pat_q,
   input logic [WORD_W-1:0] rx_q,
   input logic              ctl_cmd_sync,
   input logic              ctl_bus_b,
   input logic              dec_strobe
);
   p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(pass && fail));

   p_quiet_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (!pass && !fail));

   p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(test_en));

   p_enc_in_test_r5: assert property (@(posedge clk) disable iff (!rst_n)
      enc_valid |-> busy);

   p_enc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_valid && !enc_ready && !soft_rst) |=> enc_valid);

   p_enc_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
      enc_valid |-> (enc_data == pat_q && enc_cmd_sync == ctl_cmd_sync && enc_bus_b == ctl_bus_b));

   p_tmo_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !$past(soft_rst) && !$past(dec_strobe)) |-> fail);

   p_keep_pat_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst && !(wr_en && !wr_sel)) |=> $stable(pat_q));

   p_idle_rx_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !soft_rst) |=> $stable(rx_q));
endmodule

bind busloop_selftest busloop_chk #(.WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .test_en(test_en),
   .wr_en(wr_en), .wr_sel(wr_sel), .busy(busy), .pass(pass), .fail(fail),
   .enc_valid(enc_valid), .enc_ready(enc_ready), .enc_data(enc_data),
   .enc_cmd_sync(enc_cmd_sync), .enc_bus_b(enc_bus_b), .pat_q(pat_q), .rx_q(rx_q),
   .ctl_cmd_sync(ctl_cmd_sync), .ctl_bus_b(ctl_bus_b), .dec_strobe(dec_strobe)
);

// File: tb/busloop_selftest_bench.sv
`timescale 1ns/1ps
module busloop_selftest_bench;
   localparam int unsigned W  = 16;
   localparam int unsigned TO = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic soft_rst = 1'b0, test_en = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] pat_q, rx_q, enc_data;
   logic ctl_cmd_sync, ctl_bus_b, busy, pass, fail, enc_valid, enc_cmd_sync, enc_bus_b;
   logic enc_ready = 1'b0, dec_strobe = 1'b0, dec_cmd_sync = 1'b0;
   logic dec_manch_err = 1'b0, dec_par_err = 1'b0;
   logic [W-1:0] dec_data = '0;

   int n_run = 0, n_fail = 0;
   logic [W-1:0] exp_rx = '0;

   typedef struct {logic [W-1:0] rx; logic ps; logic fl; string req;} exp_t;
   exp_t sbq[$];

   always #10 clk = ~clk;

   busloop_selftest #(.WORD_W(W), .TIMEOUT_CYC(TO)) u_busloop_selftest (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .test_en(test_en),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .pat_q(pat_q), .rx_q(rx_q), .ctl_cmd_sync(ctl_cmd_sync), .ctl_bus_b(ctl_bus_b),
      .busy(busy), .pass(pass), .fail(fail),
      .enc_valid(enc_valid), .enc_ready(enc_ready), .enc_data(enc_data),
      .enc_cmd_sync(enc_cmd_sync), .enc_bus_b(enc_bus_b),
      .dec_strobe(dec_strobe), .dec_data(dec_data), .dec_cmd_sync(dec_cmd_sync),
      .dec_manch_err(dec_manch_err), .dec_par_err(dec_par_err)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic host_wr(logic sel, logic [W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // monitor: compare verdicts as tests finish
   logic prev_busy = 1'b0;
   always @(negedge clk) begin
      if (rst_n && prev_busy && !busy && sbq.size() > 0) begin
         exp_t e;
         e = sbq.pop_front();
         check({e.req, " rx"},   32'(rx_q), 32'(e.rx));
         check({e.req, " pass"}, 32'(pass), 32'(e.ps));
         check({e.req, " fail"}, 32'(fail), 32'(e.fl));
      end
      prev_busy = busy;
   end

   // driver: one full loopback test
   task automatic run_test(logic [W-1:0] pat, logic sy, logic bs, logic tmo,
                           logic [W-1:0] rd, logic rsy, logic me, logic pe,
                           logic poke, string req);
      exp_t e;
      logic err;
      int n;
      host_wr(1'b0, pat);
      err = me | pe | (rsy != sy) | (rd != pat);
      if (tmo) e = '{rx: exp_rx, ps: 1'b0, fl: 1'b1, req: req};
      else begin
         e = '{rx: rd, ps: !err, fl: err, req: req};
         exp_rx = rd;
      end
      sbq.push_back(e);
      host_wr(1'b1, W'({bs, sy}) | W'(4));
      check("R4 busy at start", 32'(busy), 1);
      check("R4 flags clear at start", 32'({pass, fail}), 0);
      check("R5 enc_valid", 32'(enc_valid), 1);
      check("R5 enc fields", 32'({enc_data, enc_cmd_sync, enc_bus_b}), 32'({pat, sy, bs}));
      @(negedge clk); @(negedge clk);
      check("R5 hold without ready", 32'(enc_valid), 1);
      enc_ready = 1'b1;
      @(negedge clk);
      enc_ready = 1'b0;
      check("R5 drop after handshake", 32'(enc_valid), 0);
      if (poke) begin
         host_wr(1'b0, ~pat);
         host_wr(1'b1, W'({~bs, ~sy}) | W'(4));
         n = 4;
      end else n = 0;
      if (tmo) begin
         while (busy && n < TO + 10) begin @(negedge clk); n++; end
         check("R9 timeout cycle count", 32'(n), 32'(TO));
      end else begin
         @(negedge clk); @(negedge clk);
         dec_data = rd; dec_cmd_sync = rsy; dec_manch_err = me; dec_par_err = pe;
         dec_strobe = 1'b1;
         @(negedge clk);
         dec_strobe = 1'b0; dec_manch_err = 1'b0; dec_par_err = 1'b0;
         check("R6 busy cleared at strobe", 32'(busy), 0);
      end
      if (poke) begin
         check("R2 pattern write ignored while busy", 32'(pat_q), 32'(pat));
         check("R2 control write ignored while busy", 32'({ctl_cmd_sync, ctl_bus_b}), 32'({sy, bs}));
      end
      @(negedge clk);
   endtask

   initial begin
      #(20 * 100000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset pat/rx", 32'({pat_q, rx_q}), 0);
      check("R1 reset flags", 32'({ctl_cmd_sync, ctl_bus_b, busy, pass, fail, enc_valid}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: start with test_en low
      host_wr(1'b1, W'(7));
      check("R3 no start when test_en low", 32'({busy, pass, fail}), 0);
      check("R3 selects still written", 32'({ctl_cmd_sync, ctl_bus_b}), 32'(2'b11));
      host_wr(1'b0, 16'h1234);
      check("R2 pattern write when idle", 32'(pat_q), 32'h1234);
      test_en = 1'b1;

      run_test(16'hA5C3, 1'b1, 1'b0, 1'b0, 16'hA5C3, 1'b1, 1'b0, 1'b0, 1'b0, "R7 clean echo bus A cmd");
      run_test(16'h0F0F, 1'b0, 1'b1, 1'b0, 16'h0F0F, 1'b0, 1'b0, 1'b0, 1'b1, "R7 clean echo bus B data");
      run_test(16'h3C3C, 1'b1, 1'b1, 1'b0, 16'h3C3C, 1'b1, 1'b1, 1'b0, 1'b0, "R8 manchester error");
      run_test(16'h5555, 1'b0, 1'b0, 1'b0, 16'h5555, 1'b0, 1'b0, 1'b1, 1'b0, "R8 parity error");
      run_test(16'h8001, 1'b1, 1'b0, 1'b0, 16'h8001, 1'b0, 1'b0, 1'b0, 1'b0, "R8 wrong sync");
      run_test(16'hBEEF, 1'b0, 1'b1, 1'b0, 16'hBEEE, 1'b0, 1'b0, 1'b0, 1'b0, "R8 data mismatch");
      run_test(16'h7E7E, 1'b1, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, "R9 timeout");

      // R3: start with test_en low keeps the fail flag
      test_en = 1'b0;
      host_wr(1'b1, W'(4));
      check("R3 ignored start keeps status", 32'({busy, pass, fail}), 32'(3'b001));
      test_en = 1'b1;

      // R12: stray strobe while idle
      @(negedge clk);
      dec_data = 16'hDEAD; dec_strobe = 1'b1;
      @(negedge clk);
      dec_strobe = 1'b0;
      check("R12 idle strobe rx unchanged", 32'(rx_q), 32'(exp_rx));
      check("R12 idle strobe status unchanged", 32'({pass, fail}), 32'(2'b01));

      run_test(16'h2468, 1'b0, 1'b0, 1'b0, 16'h2468, 1'b0, 1'b0, 1'b0, 1'b0, "R4 pass after fail");

      // R10: soft reset mid-test
      host_wr(1'b0, 16'hC0DE);
      host_wr(1'b1, W'(7));
      check("R10 test running", 32'(busy), 1);
      @(negedge clk);
      soft_rst = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0;
      check("R10 soft reset clears", 32'({ctl_cmd_sync, ctl_bus_b, busy, pass, fail, enc_valid}), 0);
      check("R10 soft reset rx", 32'(rx_q), 0);
      check("R10 pattern kept", 32'(pat_q), 32'hC0DE);
      exp_rx = '0;
      run_test(16'hC0DE, 1'b1, 1'b1, 1'b0, 16'hC0DE, 1'b1, 1'b0, 1'b0, 1'b0, "R6 capture after soft reset");

      check("R11 scoreboard drained", 32'(sbq.size()), 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule